// File: doc/BRIEF.md
# Multi-Issue Unary Dependency Accumulator

This block sits at the front of an issue stage that sends several instructions per clock into a scoreboard-style dependency matrix. Each slot of the issue group carries a destination register number and a set of source register numbers. Each number has its own enable. The block turns every enabled number into a one-hot register vector with one bit per architectural register.

Dependencies inside an issue group are transitive. A later instruction must respect every hazard of the instructions ahead of it. For that reason, the vector of each slot is merged with the vectors of all earlier slots by a cascading OR. No per-slot comparison of register numbers is needed.

Read hazards (sources) and write hazards (destinations) are accumulated separately. Both cumulative vectors of every slot are registered and drive the rows of the dependency matrix one clock after the group is presented. A fresh group can be presented every clock.

Top module: `issue_dep_accum`

## Requirements
- R1: For a valid slot with its write enable high and destination index k (1 ≤ k < NREGS), bit k of that slot's write-hazard vector is set. Output vectors are flat: slot s occupies bits [s*NREGS +: NREGS], and bit k within a slot stands for register k.
- R2: For a valid slot, each source j whose enable is high sets bit (its index) of that slot's read-hazard vector. Source j of slot s uses enable bit s*NSRC+j and index bits [(s*NSRC+j)*IDXW +: IDXW].
- R3: The write vector of slot s is the OR of the own write vectors of slots 0..s. The read vector of slot s is the OR of the own read vectors of slots 0..s. As a result, every bit set in slot s-1 is also set in slot s.
- R4: A slot whose valid bit is low adds no bits, whatever its enables and indices are. Its outputs equal those of the slot before it, or all zeros for slot 0.
- R5: A destination or source whose enable is low adds no bit, even in a valid slot.
- R6: Register 0 is never marked. Bit 0 of every output vector is always 0.
- R7: Outputs change exactly one clock after the issue inputs are sampled. They depend only on the group sampled at that edge, so nothing carries over from earlier groups.
- R8: While rst_n is low at a rising edge, all output vectors are cleared to zero on that edge.
- R9: Slot 0's outputs hold only slot 0's own registers. Later slots never affect earlier ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld | input | SLOTS | Per-slot valid bit of the issue group |
| dst_en | input | SLOTS | Per-slot destination write enable |
| dst_idx | input | SLOTS*IDXW | Per-slot destination register number |
| src_en | input | SLOTS*NSRC | Per-source read enable |
| src_idx | input | SLOTS*NSRC*IDXW | Per-source register number |
| wr_haz | output | SLOTS*NREGS | Cumulative write-hazard vectors, one per slot |
| rd_haz | output | SLOTS*NREGS | Cumulative read-hazard vectors, one per slot |

## Verification
Every hazard vector is due one clock after its group is sampled. The bench drives each group on a falling edge, lets a single rising edge capture it, and compares all slots on the next falling edge. It compares them against a behavioural model that works out the expected vectors for the group it has just driven. Reset is checked in the same way: the edge that samples rst_n low must produce all-zero vectors. A group followed by an empty group shows that nothing is carried over between groups.

// File: rtl/dep_pkg.sv
package dep_pkg;
    localparam int DEF_SLOTS = 4;
    localparam int DEF_NREGS = 32;
    localparam int DEF_NSRC  = 2;

    function automatic int idx_width(input int nregs);
        return (nregs > 1) ? $clog2(nregs) : 1;
    endfunction
endpackage

// File: rtl/reg_to_unary.sv
module reg_to_unary #(
    parameter int NREGS     = 32,
    parameter int IDXW      = 5,
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic             en,
    input  logic [IDXW-1:0]  idx,
    output logic [NREGS-1:0] vec
);
    always_comb begin
        vec = '0;
        if (en && (int'(idx) < NREGS) && !(SKIP_ZERO && idx == '0)) begin
            vec[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/slot_vectors.sv
module slot_vectors #(
    parameter int NREGS = 32,
    parameter int IDXW  = 5,
    parameter int NSRC  = 2
) (
    input  logic                 vld,
    input  logic                 wen,
    input  logic [IDXW-1:0]      widx,
    input  logic [NSRC-1:0]      sen,
    input  logic [NSRC*IDXW-1:0] sidx,
    output logic [NREGS-1:0]     wvec,
    output logic [NREGS-1:0]     rvec
);
    logic [NSRC-1:0][NREGS-1:0] src_vec;

    reg_to_unary #(.NREGS(NREGS), .IDXW(IDXW), .SKIP_ZERO(1'b1)) u_dst (
        .en  (vld && wen),
        .idx (widx),
        .vec (wvec)
    );

    for (genvar j = 0; j < NSRC; j++) begin : g_src
        reg_to_unary #(.NREGS(NREGS), .IDXW(IDXW), .SKIP_ZERO(1'b1)) u_src (
            .en  (vld && sen[j]),
            .idx (sidx[j*IDXW +: IDXW]),
            .vec (src_vec[j])
        );
    end

    always_comb begin
        rvec = '0;
        for (int j = 0; j < NSRC; j++) begin
            rvec = rvec | src_vec[j];
        end
    end
endmodule

// File: rtl/prefix_or.sv
module prefix_or #(
    parameter int SLOTS = 4,
    parameter int NREGS = 32
) (
    input  logic [SLOTS-1:0][NREGS-1:0] own,
    output logic [SLOTS-1:0][NREGS-1:0] cum
);
    always_comb begin
        cum[0] = own[0];
        for (int s = 1; s < SLOTS; s++) begin
            cum[s] = cum[s-1] | own[s];
        end
    end
endmodule

// File: rtl/issue_dep_accum.sv
module issue_dep_accum
    import dep_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int NREGS = DEF_NREGS,
    parameter int NSRC  = DEF_NSRC,
    parameter int IDXW  = idx_width(NREGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SLOTS-1:0]            slot_vld,
    input  logic [SLOTS-1:0]            dst_en,
    input  logic [SLOTS*IDXW-1:0]       dst_idx,
    input  logic [SLOTS*NSRC-1:0]       src_en,
    input  logic [SLOTS*NSRC*IDXW-1:0]  src_idx,
    output logic [SLOTS*NREGS-1:0]      wr_haz,
    output logic [SLOTS*NREGS-1:0]      rd_haz
);
    localparam int SRCW = NSRC * IDXW;

    typedef struct packed {
        logic [SLOTS-1:0][NREGS-1:0] wr;
        logic [SLOTS-1:0][NREGS-1:0] rd;
    } haz_t;

    logic [SLOTS-1:0][NREGS-1:0] own_wr, own_rd, cum_wr, cum_rd;
    haz_t st_d, st_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        slot_vectors #(.NREGS(NREGS), .IDXW(IDXW), .NSRC(NSRC)) u_vec (
            .vld  (slot_vld[s]),
            .wen  (dst_en[s]),
            .widx (dst_idx[s*IDXW +: IDXW]),
            .sen  (src_en[s*NSRC +: NSRC]),
            .sidx (src_idx[s*SRCW +: SRCW]),
            .wvec (own_wr[s]),
            .rvec (own_rd[s])
        );
    end

    prefix_or #(.SLOTS(SLOTS), .NREGS(NREGS)) u_wr_chain (
        .own (own_wr),
        .cum (cum_wr)
    );

    prefix_or #(.SLOTS(SLOTS), .NREGS(NREGS)) u_rd_chain (
        .own (own_rd),
        .cum (cum_rd)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wr = cum_wr;
        st_d.rd = cum_rd;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_haz = st_q.wr;
    assign rd_haz = st_q.rd;

    // Assertions guarding the registered hazard rows
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (wr_haz == '0 && rd_haz == '0));

    p_dst_marked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(slot_vld[0] && dst_en[0]) && $past(dst_idx[IDXW-1:0]) != '0
         && int'($past(dst_idx[IDXW-1:0])) < NREGS)
        |-> st_q.wr[0][$past(dst_idx[IDXW-1:0])]);

    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        p_no_zero_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.wr[s][0] == 1'b0 && st_q.rd[s][0] == 1'b0));
        if (s > 0) begin : g_later
            p_cascade_superset_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ((st_q.wr[s-1] & ~st_q.wr[s]) == '0 && (st_q.rd[s-1] & ~st_q.rd[s]) == '0));
            p_idle_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(slot_vld[s]))
                |-> (st_q.wr[s] == st_q.wr[s-1] && st_q.rd[s] == st_q.rd[s-1]));
        end else begin : g_first
            p_idle_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(slot_vld[0]))
                |-> (st_q.wr[0] == '0 && st_q.rd[0] == '0));
        end
    end
endmodule

// File: tb/sim_issue_dep_accum.sv
module sim_issue_dep_accum;
    localparam int SLOTS = 4;
    localparam int NREGS = 32;
    localparam int NSRC  = 2;
    localparam int IDXW  = 5;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [SLOTS-1:0]            slot_vld = '0;
    logic [SLOTS-1:0]            dst_en = '0;
    logic [SLOTS*IDXW-1:0]       dst_idx = '0;
    logic [SLOTS*NSRC-1:0]       src_en = '0;
    logic [SLOTS*NSRC*IDXW-1:0]  src_idx = '0;
    logic [SLOTS*NREGS-1:0]      wr_haz, rd_haz;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    issue_dep_accum #(.SLOTS(SLOTS), .NREGS(NREGS), .NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .dst_en(dst_en),
        .dst_idx(dst_idx), .src_en(src_en), .src_idx(src_idx),
        .wr_haz(wr_haz), .rd_haz(rd_haz)
    );

    task automatic set_slot(input int s, input bit v, input bit we, input int wd,
                            input bit e0, input int a0, input bit e1, input int a1);
        slot_vld[s] = v;
        dst_en[s]   = we;
        dst_idx[s*IDXW +: IDXW] = IDXW'(wd);
        src_en[s*NSRC]     = e0;
        src_en[s*NSRC + 1] = e1;
        src_idx[(s*NSRC)*IDXW +: IDXW]     = IDXW'(a0);
        src_idx[(s*NSRC + 1)*IDXW +: IDXW] = IDXW'(a1);
    endtask

    task automatic clear_group();
        for (int s = 0; s < SLOTS; s++) set_slot(s, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Behavioural model: walk slots in order, keep a running set of marked registers
    task automatic step(input string lbl);
        logic [SLOTS*NREGS-1:0] ew, er;
        bit run_w[NREGS];
        bit run_r[NREGS];
        ew = '0; er = '0;
        for (int k = 0; k < NREGS; k++) begin run_w[k] = 0; run_r[k] = 0; end
        if (rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (slot_vld[s]) begin
                    int d;
                    d = int'(dst_idx[s*IDXW +: IDXW]);
                    if (dst_en[s] && d != 0) run_w[d] = 1;
                    for (int j = 0; j < NSRC; j++) begin
                        int r;
                        r = int'(src_idx[(s*NSRC + j)*IDXW +: IDXW]);
                        if (src_en[s*NSRC + j] && r != 0) run_r[r] = 1;
                    end
                end
                for (int k = 0; k < NREGS; k++) begin
                    ew[s*NREGS + k] = run_w[k];
                    er[s*NREGS + k] = run_r[k];
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < SLOTS; s++) begin
            n_checks++;
            if (wr_haz[s*NREGS +: NREGS] !== ew[s*NREGS +: NREGS]) begin
                n_fail++;
                $display("FAIL %s slot%0d write: actual %h expected %h", lbl, s,
                         wr_haz[s*NREGS +: NREGS], ew[s*NREGS +: NREGS]);
            end
            n_checks++;
            if (rd_haz[s*NREGS +: NREGS] !== er[s*NREGS +: NREGS]) begin
                n_fail++;
                $display("FAIL %s slot%0d read: actual %h expected %h", lbl, s,
                         rd_haz[s*NREGS +: NREGS], er[s*NREGS +: NREGS]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R8: reset clears outputs even with an active group
        set_slot(0, 1, 1, 5, 1, 6, 1, 7);
        step("R8 reset with group");
        rst_n = 1'b1;
        clear_group();
        step("R7 empty group after reset");

        // R1: destination one-hot
        set_slot(0, 1, 1, 5, 0, 0, 0, 0);
        step("R1 single dest r5");
        // R2: source one-hot
        clear_group();
        set_slot(0, 1, 0, 0, 1, 3, 1, 7);
        step("R2 sources r3 r7");
        // R3 and R9: four distinct slots
        set_slot(0, 1, 1, 1, 1, 2, 1, 3);
        set_slot(1, 1, 1, 4, 1, 5, 1, 6);
        set_slot(2, 1, 1, 8, 1, 9, 0, 10);
        set_slot(3, 1, 1, 31, 1, 30, 1, 29);
        step("R3 R9 four-slot cascade");
        // R7: nothing carried into an empty group
        clear_group();
        step("R7 no carry-over");
        // R4: invalid slot with live fields
        set_slot(0, 1, 1, 11, 1, 12, 0, 0);
        set_slot(1, 0, 1, 13, 1, 14, 1, 15);
        set_slot(2, 1, 1, 16, 0, 0, 1, 17);
        set_slot(3, 0, 1, 18, 1, 19, 1, 20);
        step("R4 invalid slots pass through");
        set_slot(0, 0, 1, 21, 1, 22, 1, 23);
        step("R4 invalid slot0");
        // R5: enables low
        clear_group();
        set_slot(0, 1, 0, 9, 0, 10, 1, 11);
        set_slot(1, 1, 1, 12, 0, 13, 0, 14);
        step("R5 disabled fields ignored");
        // R6: register zero
        for (int s = 0; s < SLOTS; s++) set_slot(s, 1, 1, 0, 1, 0, 1, 0);
        step("R6 reg zero never marked");
        set_slot(2, 1, 1, 0, 1, 1, 1, 0);
        step("R6 mixed zero");
        // Random groups
        for (int i = 0; i < 60; i++) begin
            for (int s = 0; s < SLOTS; s++)
                set_slot(s, 1'($urandom), 1'($urandom), $urandom % NREGS,
                         1'($urandom), $urandom % NREGS, 1'($urandom), $urandom % NREGS);
            step("R3 random group");
        end
        // R8: reset mid-run
        rst_n = 1'b0;
        step("R8 mid-run reset");
        rst_n = 1'b1;
        step("R7 after release");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule